// File: doc/BRIEF.md
# Asynchronous Serial Port with Loopback Self-Test

This block is a byte-wide asynchronous serial port: one transmitter, one receiver and a small register file reached over a simple synchronous bus with a 3-bit offset. Software programs the frame (word length, parity, stop length) and a 16-bit baud divisor. It queues bytes into a holding register and reads received bytes back, polling a status register to see when each side is ready.

Both directions share a 16x oversampling tick made from the divisor. The receiver finds the start edge, confirms it at the middle of the start bit, and then samples each later bit at its centre. A mode bit ties the transmitter's serial output straight into the receiver. With that bit set, software can check its own send and receive paths without any wiring. The external output then rests at the mark level.

Top module: `sio_uart`

## Requirements
- R1: After reset the line status register (offset 5) reads 0x60, the line control register (offset 3) reads 0x00, `txd_out` is 1 and `dtr_out`/`rts_out` are 0.
- R2: With line control bit 7 set, offsets 0 and 1 write and read the low and high bytes of the baud divisor. With bit 7 clear, a write to offset 0 goes to the transmitter and leaves the divisor unchanged.
- R3: Every serial bit lasts 16 x divisor clock cycles. A divisor of 0 behaves as 1.
- R4: The transmit frame is one start bit (0), then the data bits LSB first, then an optional parity bit, then one stop bit (1), or two when line control bit 2 is set. The data width is 5 + line control bits [1:0]. The parity bit is present when bit 3 is set; it gives even parity over the data bits when bit 4 is set and odd parity when bit 4 is clear.
- R5: Line status bit 5 is 1 while the holding register is empty. Bit 6 is 1 only when the holding register is empty and the shifter is idle. A write to the transmitter clears both in the next cycle. A second byte may be queued while the first is still shifting, and both are sent in order.
- R6: A received byte reads at offset 0, with bits above the word length read as 0. Line status bit 0 sets when the stop bit is sampled and clears after offset 0 is read.
- R7: Line status bit 2 flags a parity mismatch and bit 3 flags a stop bit sampled as 0. Both stay set until the line status register is read.
- R8: With modem control bit 4 set, the transmitted stream enters the receiver and bytes read back unchanged. `txd_out` stays at 1 and `rxd_in` is ignored. Clearing the bit restores normal output.
- R9: Modem control bits 0 and 1 drive `dtr_out` and `rts_out`.
- R10: A low pulse on the receive line that ends before the middle of a start bit produces no byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (drives read side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| rxd_in | input | 1 | External serial input |
| txd_out | output | 1 | External serial output |
| dtr_out | output | 1 | Terminal-ready output |
| rts_out | output | 1 | Request-to-send output |

## Verification
A register write takes effect at the clock edge that samples it. Status bits that depend on it (holding-register empty, shifter idle, modem outputs) are therefore checked half a cycle later. The shifter loads one cycle after that, so the start bit appears on the line two edges after the write strobe is presented. The bench detects that falling edge and then samples each bit at its centre, 8 + 16·k cycles later with a divisor of 1. Bit period is measured between two data transitions rather than from the start edge, because the start bit may carry up to one extra divisor period. Received data and error flags appear two synchronizer cycles after the middle of the stop bit, so the bench reads them only after the whole stop bit has been driven.

// File: rtl/sio_pkg.sv
package sio_pkg;

    localparam int BYTE_W = 8;

    localparam logic [2:0] OFS_DATA = 3'd0;
    localparam logic [2:0] OFS_DIVH = 3'd1;
    localparam logic [2:0] OFS_LINE = 3'd3;
    localparam logic [2:0] OFS_MDM  = 3'd4;
    localparam logic [2:0] OFS_STAT = 3'd5;

    typedef struct packed {
        logic       dlab;
        logic [1:0] spare;
        logic       even;
        logic       pen;
        logic       stop2;
        logic [1:0] wlen;
    } line_ctl_t;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              perr;
        logic              ferr;
    } rx_word_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } bit_state_e;

    function automatic logic [2:0] last_index(input logic [1:0] wlen);
        return {1'b1, wlen};
    endfunction

    function automatic logic [BYTE_W-1:0] word_mask(input logic [1:0] wlen);
        case (wlen)
            2'd0:    return 8'h1F;
            2'd1:    return 8'h3F;
            2'd2:    return 8'h7F;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic frame_parity(input logic [BYTE_W-1:0] d,
                                          input logic [1:0] wlen,
                                          input logic even);
        logic ones_odd;
        ones_odd = ^(d & word_mask(wlen));
        return even ? ones_odd : ~ones_odd;
    endfunction

endpackage

// File: rtl/sio_baud.sv
module sio_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic             wrap;

    assign wrap = (divisor <= DIV_W'(1)) || (cnt >= divisor - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (wrap) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/sio_tx.sv
module sio_tx
    import sio_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              load_en,
    input  logic [BYTE_W-1:0] load_byte,
    input  logic [1:0]        wlen,
    input  logic              stop2,
    input  logic              pen,
    input  logic              even,
    output logic              txd,
    output logic              thre,
    output logic              temt
);
    localparam int OW = $clog2(OVS);
    localparam logic [OW:0] LAST_ONE = (OW+1)'(OVS - 1);
    localparam logic [OW:0] LAST_TWO = (OW+1)'(2 * OVS - 1);

    bit_state_e        state;
    logic [BYTE_W-1:0] hold;
    logic [BYTE_W-1:0] shreg;
    logic              hold_full;
    logic [OW:0]       os_cnt;
    logic [2:0]        idx;
    logic [1:0]        l_wlen;
    logic              l_stop2;
    logic              l_pen;
    logic              l_par;
    logic [OW:0]       last_cnt;
    logic              bit_end;

    assign last_cnt = (state == ST_STOP && l_stop2) ? LAST_TWO : LAST_ONE;
    assign bit_end  = tick && (os_cnt == last_cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            hold      <= '0;
            shreg     <= '0;
            hold_full <= 1'b0;
            os_cnt    <= '0;
            idx       <= '0;
            l_wlen    <= '0;
            l_stop2   <= 1'b0;
            l_pen     <= 1'b0;
            l_par     <= 1'b0;
            txd       <= 1'b1;
        end else begin
            if (tick && state != ST_IDLE) begin
                os_cnt <= bit_end ? '0 : os_cnt + 1'b1;
            end
            case (state)
                ST_IDLE: begin
                    if (hold_full) begin
                        shreg     <= hold;
                        hold_full <= 1'b0;
                        l_wlen    <= wlen;
                        l_stop2   <= stop2;
                        l_pen     <= pen;
                        l_par     <= frame_parity(hold, wlen, even);
                        os_cnt    <= '0;
                        idx       <= '0;
                        txd       <= 1'b0;
                        state     <= ST_START;
                    end
                end
                ST_START: begin
                    if (bit_end) begin
                        txd   <= shreg[0];
                        state <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (bit_end) begin
                        if (idx == last_index(l_wlen)) begin
                            if (l_pen) begin
                                txd   <= l_par;
                                state <= ST_PAR;
                            end else begin
                                txd   <= 1'b1;
                                state <= ST_STOP;
                            end
                        end else begin
                            idx   <= idx + 1'b1;
                            shreg <= shreg >> 1;
                            txd   <= shreg[1];
                        end
                    end
                end
                ST_PAR: begin
                    if (bit_end) begin
                        txd   <= 1'b1;
                        state <= ST_STOP;
                    end
                end
                ST_STOP: begin
                    if (bit_end) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
            if (load_en) begin
                hold      <= load_byte;
                hold_full <= 1'b1;
            end
        end
    end

    assign thre = !hold_full;
    assign temt = !hold_full && (state == ST_IDLE);
endmodule

// File: rtl/sio_rx.sv
module sio_rx
    import sio_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       line_in,
    input  logic [1:0] wlen,
    input  logic       pen,
    input  logic       even,
    output logic       done,
    output rx_word_t   word
);
    localparam int OW = $clog2(OVS);
    localparam logic [OW-1:0] HALF = OW'(OVS / 2 - 1);
    localparam logic [OW-1:0] FULL = OW'(OVS - 1);

    bit_state_e        state;
    logic              s_meta;
    logic              s_line;
    logic [OW-1:0]     os_cnt;
    logic [2:0]        idx;
    logic [BYTE_W-1:0] shreg;
    logic              par_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            s_meta  <= 1'b1;
            s_line  <= 1'b1;
            os_cnt  <= '0;
            idx     <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
            done    <= 1'b0;
            word    <= '0;
        end else begin
            done   <= 1'b0;
            s_meta <= line_in;
            s_line <= s_meta;
            case (state)
                ST_IDLE: begin
                    if (!s_line) begin
                        os_cnt <= '0;
                        state  <= ST_START;
                    end
                end
                ST_START: begin
                    if (tick) begin
                        if (os_cnt == HALF) begin
                            os_cnt <= '0;
                            if (!s_line) begin
                                idx   <= '0;
                                shreg <= '0;
                                state <= ST_DATA;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (tick) begin
                        if (os_cnt == FULL) begin
                            os_cnt     <= '0;
                            shreg[idx] <= s_line;
                            if (idx == last_index(wlen)) begin
                                state <= pen ? ST_PAR : ST_STOP;
                            end else begin
                                idx <= idx + 1'b1;
                            end
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                end
                ST_PAR: begin
                    if (tick) begin
                        if (os_cnt == FULL) begin
                            os_cnt  <= '0;
                            par_bit <= s_line;
                            state   <= ST_STOP;
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                end
                ST_STOP: begin
                    if (tick) begin
                        if (os_cnt == FULL) begin
                            os_cnt    <= '0;
                            done      <= 1'b1;
                            word.data <= shreg;
                            word.ferr <= !s_line;
                            word.perr <= pen && (par_bit != frame_parity(shreg, wlen, even));
                            state     <= ST_IDLE;
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sio_uart.sv
module sio_uart
    import sio_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       rxd_in,
    output logic       txd_out,
    output logic       dtr_out,
    output logic       rts_out
);
    localparam int DIV_W = 2 * BYTE_W;

    line_ctl_t         lcr_q;
    logic [BYTE_W-1:0] div_lo;
    logic [BYTE_W-1:0] div_hi;
    logic [4:0]        mcr_q;
    logic [BYTE_W-1:0] rbr_q;
    logic              dr_q;
    logic              pe_q;
    logic              fe_q;

    logic              dlab;
    logic              loop_en;
    logic              tick;
    logic              tx_line;
    logic              rx_line;
    logic              tx_load;
    logic              thre;
    logic              temt;
    logic              rx_valid;
    rx_word_t          rx_word;
    logic [7:0]        lsr_val;
    logic              rd_data_hit;
    logic              rd_stat_hit;

    assign dlab        = lcr_q.dlab;
    assign loop_en     = mcr_q[4];
    assign tx_load     = bus_wr && (bus_addr == OFS_DATA) && !dlab;
    assign rd_data_hit = bus_rd && (bus_addr == OFS_DATA) && !dlab;
    assign rd_stat_hit = bus_rd && (bus_addr == OFS_STAT);
    assign lsr_val     = {1'b0, temt, thre, 1'b0, fe_q, pe_q, 1'b0, dr_q};

    sio_baud #(.DIV_W(DIV_W)) u_baud (
        .clk     (clk),
        .rst     (rst),
        .divisor ({div_hi, div_lo}),
        .tick    (tick)
    );

    sio_tx #(.OVS(OVS)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .load_en   (tx_load),
        .load_byte (bus_wdata),
        .wlen      (lcr_q.wlen),
        .stop2     (lcr_q.stop2),
        .pen       (lcr_q.pen),
        .even      (lcr_q.even),
        .txd       (tx_line),
        .thre      (thre),
        .temt      (temt)
    );

    assign rx_line = loop_en ? tx_line : rxd_in;
    assign txd_out = loop_en ? 1'b1 : tx_line;

    sio_rx #(.OVS(OVS)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .line_in (rx_line),
        .wlen    (lcr_q.wlen),
        .pen     (lcr_q.pen),
        .even    (lcr_q.even),
        .done    (rx_valid),
        .word    (rx_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lcr_q  <= '0;
            div_lo <= '0;
            div_hi <= '0;
            mcr_q  <= '0;
            rbr_q  <= '0;
            dr_q   <= 1'b0;
            pe_q   <= 1'b0;
            fe_q   <= 1'b0;
        end else begin
            if (rd_data_hit) dr_q <= 1'b0;
            if (rd_stat_hit) begin
                pe_q <= 1'b0;
                fe_q <= 1'b0;
            end
            if (rx_valid) begin
                rbr_q <= rx_word.data;
                dr_q  <= 1'b1;
                if (rx_word.perr) pe_q <= 1'b1;
                if (rx_word.ferr) fe_q <= 1'b1;
            end
            if (bus_wr) begin
                case (bus_addr)
                    OFS_DATA: if (dlab) div_lo <= bus_wdata;
                    OFS_DIVH: if (dlab) div_hi <= bus_wdata;
                    OFS_LINE: lcr_q <= line_ctl_t'(bus_wdata);
                    OFS_MDM:  mcr_q <= bus_wdata[4:0];
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_DATA: bus_rdata = dlab ? div_lo : rbr_q;
            OFS_DIVH: bus_rdata = dlab ? div_hi : 8'h00;
            OFS_LINE: bus_rdata = lcr_q;
            OFS_MDM:  bus_rdata = {3'b000, mcr_q};
            OFS_STAT: bus_rdata = lsr_val;
            default:  bus_rdata = 8'h00;
        endcase
    end

    assign dtr_out = mcr_q[0];
    assign rts_out = mcr_q[1];
endmodule

// File: rtl/sio_uart_chk.sv
module sio_uart_chk
    import sio_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [2:0] bus_addr,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [7:0] bus_wdata,
    input logic       dlab,
    input logic [7:0] lsr_val,
    input logic       rx_valid,
    input logic       dtr_out,
    input logic       rts_out
);
    p_idle_needs_empty_r5: assert property (@(posedge clk) disable iff (rst)
        lsr_val[6] |-> lsr_val[5]);

    p_write_marks_busy_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_DATA && !dlab) |=> (!lsr_val[5] && !lsr_val[6]));

    p_data_read_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == OFS_DATA && !dlab && !rx_valid) |=> !lsr_val[0]);

    p_byte_sets_ready_r6: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> lsr_val[0]);

    p_status_read_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == OFS_STAT && !rx_valid) |=> (!lsr_val[2] && !lsr_val[3]));

    p_modem_pins_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_MDM) |=>
            (dtr_out == $past(bus_wdata[0]) && rts_out == $past(bus_wdata[1])));
endmodule

bind sio_uart sio_uart_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .dlab      (dlab),
    .lsr_val   (lsr_val),
    .rx_valid  (rx_valid),
    .dtr_out   (dtr_out),
    .rts_out   (rts_out)
);

// File: tb/tb_sio_uart.sv
module tb_sio_uart;
    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] bus_addr;
    logic       bus_wr;
    logic       bus_rd;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       rxd_in;
    logic       txd_out;
    logic       dtr_out;
    logic       rts_out;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sio_uart dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rxd_in    (rxd_in),
        .txd_out   (txd_out),
        .dtr_out   (dtr_out),
        .rts_out   (rts_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic par_of(input logic [7:0] d, input int nbits, input logic even);
        logic p = 1'b0;
        for (int i = 0; i < nbits; i++) p ^= d[i];
        return even ? p : ~p;
    endfunction

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 3'd5;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; bus_addr = 3'd5;
    endtask

    task automatic peek_lsr(output logic [7:0] v);
        bus_addr = 3'd5;
        #1 v = bus_rdata;
    endtask

    task automatic wait_lsr(input int bitn, input string req);
        logic [7:0] v;
        int n = 0;
        peek_lsr(v);
        while (v[bitn] !== 1'b1 && n < 20000) begin
            @(negedge clk); n++;
            peek_lsr(v);
        end
        if (n >= 20000) chk({req, " lsr wait timeout"}, 0, 1);
    endtask

    task automatic wait_txd(input logic level, output int cycles);
        cycles = 0;
        while (txd_out !== level && cycles < 20000) begin
            @(negedge clk); cycles++;
        end
    endtask

    task automatic capture_frame(input logic [7:0] exp, input int nbits, input logic pen,
                                 input logic even, input logic stop2, input string req);
        int c;
        logic [7:0] v;
        wait_txd(1'b0, c);
        repeat (8) @(negedge clk);
        chk({req, " start bit"}, txd_out, 0);
        for (int i = 0; i < nbits; i++) begin
            repeat (16) @(negedge clk);
            chk({req, " data bit"}, txd_out, exp[i]);
        end
        if (pen) begin
            repeat (16) @(negedge clk);
            chk({req, " parity bit"}, txd_out, par_of(exp, nbits, even));
        end
        repeat (16) @(negedge clk);
        chk({req, " stop bit"}, txd_out, 1);
        repeat (16) @(negedge clk);
        peek_lsr(v);
        chk({req, " second stop slot idle flag"}, v[6], !stop2);
    endtask

    task automatic send_serial(input logic [7:0] d, input int nbits, input logic with_par,
                               input logic par, input logic stop_val);
        @(negedge clk);
        rxd_in = 1'b0; repeat (16) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            rxd_in = d[i]; repeat (16) @(negedge clk);
        end
        if (with_par) begin
            rxd_in = par; repeat (16) @(negedge clk);
        end
        rxd_in = stop_val; repeat (16) @(negedge clk);
        rxd_in = 1'b1; repeat (24) @(negedge clk);
    endtask

    task automatic set_divisor(input logic [15:0] dv, input logic [7:0] lcr);
        bus_write(3'd3, 8'h80);
        bus_write(3'd0, dv[7:0]);
        bus_write(3'd1, dv[15:8]);
        bus_write(3'd3, lcr);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        bus_read(3'd5, v); chk("R1 status after reset", v, 8'h60);
        bus_read(3'd3, v); chk("R1 line control after reset", v, 8'h00);
        chk("R1 txd idle", txd_out, 1);
        chk("R1 dtr/rts low", {dtr_out, rts_out}, 2'b00);
    endtask

    task automatic t_divisor;
        logic [7:0] v;
        bus_write(3'd3, 8'h80);
        bus_write(3'd0, 8'h34);
        bus_write(3'd1, 8'h12);
        bus_read(3'd0, v); chk("R2 divisor low readback", v, 8'h34);
        bus_read(3'd1, v); chk("R2 divisor high readback", v, 8'h12);
        bus_write(3'd3, 8'h03);
        bus_write(3'd0, 8'hA5);
        bus_write(3'd3, 8'h83);
        bus_read(3'd0, v); chk("R2 data write leaves divisor", v, 8'h34);
        set_divisor(16'd1, 8'h03);
        wait_lsr(6, "R2");
    endtask

    task automatic t_period;
        int c;
        set_divisor(16'd3, 8'h03);
        bus_write(3'd0, 8'h55);
        wait_txd(1'b0, c);
        wait_txd(1'b1, c);
        wait_txd(1'b0, c); chk("R3 bit period divisor 3 (1->0)", c, 48);
        wait_txd(1'b1, c); chk("R3 bit period divisor 3 (0->1)", c, 48);
        wait_lsr(6, "R3");
        set_divisor(16'd0, 8'h03);
        bus_write(3'd0, 8'h55);
        wait_txd(1'b0, c);
        wait_txd(1'b1, c);
        wait_txd(1'b0, c); chk("R3 bit period divisor 0", c, 16);
        wait_lsr(6, "R3");
        set_divisor(16'd1, 8'h03);
    endtask

    task automatic t_frames;
        bus_write(3'd3, 8'h1B);
        bus_write(3'd0, 8'hC6);
        capture_frame(8'hC6, 8, 1'b1, 1'b1, 1'b0, "R4 8 bits even parity");
        bus_write(3'd3, 8'h0C);
        bus_write(3'd0, 8'h0D);
        capture_frame(8'h0D, 5, 1'b1, 1'b0, 1'b1, "R4 5 bits odd parity two stops");
        wait_lsr(6, "R4");
        bus_write(3'd3, 8'h06);
        bus_write(3'd0, 8'h5A);
        capture_frame(8'h5A, 7, 1'b0, 1'b0, 1'b1, "R4 7 bits no parity two stops");
        wait_lsr(6, "R4");
    endtask

    task automatic t_loop_queue;
        logic [7:0] v;
        int txd_low = 0;
        bus_write(3'd3, 8'h1B);
        bus_write(3'd4, 8'h10);
        rxd_in = 1'b0;
        bus_write(3'd0, 8'h3C);
        peek_lsr(v); chk("R5 write clears empty and idle", v[6:5], 2'b00);
        @(negedge clk);
        peek_lsr(v); chk("R5 holding empty while shifting", v[6:5], 2'b01);
        bus_write(3'd0, 8'hC3);
        peek_lsr(v); chk("R5 second byte queued", v[6:5], 2'b00);
        peek_lsr(v);
        while (v[0] !== 1'b1 && txd_low < 100000) begin
            @(negedge clk);
            if (txd_out !== 1'b1) txd_low += 1000;
            peek_lsr(v);
        end
        bus_read(3'd0, v); chk("R8 loopback first byte", v, 8'h3C);
        peek_lsr(v); chk("R6 ready cleared by data read", v[0], 0);
        peek_lsr(v);
        while (v[0] !== 1'b1 && txd_low < 100000) begin
            @(negedge clk);
            if (txd_out !== 1'b1) txd_low += 1000;
            peek_lsr(v);
        end
        bus_read(3'd0, v); chk("R8 loopback second byte (R5 order)", v, 8'hC3);
        chk("R8 txd held at mark in loopback", txd_low, 0);
        wait_lsr(6, "R8");
        rxd_in = 1'b1;
        repeat (4) @(negedge clk);
        bus_write(3'd4, 8'h00);
        bus_write(3'd0, 8'h81);
        capture_frame(8'h81, 8, 1'b1, 1'b1, 1'b0, "R8 normal output restored");
    endtask

    task automatic t_receive;
        logic [7:0] v;
        bus_write(3'd3, 8'h02);
        send_serial(8'hFF, 7, 1'b0, 1'b0, 1'b1);
        peek_lsr(v); chk("R6 ready after 7-bit byte", v[0], 1);
        bus_read(3'd0, v); chk("R6 upper bits zero", v, 8'h7F);
        peek_lsr(v); chk("R6 ready cleared", v[0], 0);
        bus_write(3'd3, 8'h1B);
        send_serial(8'hA5, 8, 1'b1, par_of(8'hA5, 8, 1'b1), 1'b1);
        peek_lsr(v); chk("R7 no errors on good frame", v[3:2], 2'b00);
        bus_read(3'd0, v); chk("R6 8-bit byte", v, 8'hA5);
        send_serial(8'h3A, 8, 1'b1, ~par_of(8'h3A, 8, 1'b1), 1'b1);
        peek_lsr(v); chk("R7 parity error flagged", v[3:2], 2'b01);
        bus_read(3'd5, v);
        peek_lsr(v); chk("R7 errors cleared by status read", v[3:2], 2'b00);
        send_serial(8'h11, 8, 1'b1, par_of(8'h11, 8, 1'b1), 1'b0);
        peek_lsr(v); chk("R7 framing error flagged", v[3:2], 2'b10);
        bus_read(3'd5, v);
        bus_read(3'd0, v);
        peek_lsr(v); chk("R7 no stray byte after bad stop", v[0], 0);
    endtask

    task automatic t_false_start;
        logic [7:0] v;
        @(negedge clk);
        rxd_in = 1'b0; repeat (4) @(negedge clk);
        rxd_in = 1'b1; repeat (300) @(negedge clk);
        peek_lsr(v); chk("R10 short low pulse ignored", v[0], 0);
    endtask

    task automatic t_modem;
        bus_write(3'd4, 8'h01);
        chk("R9 dtr set rts clear", {dtr_out, rts_out}, 2'b10);
        bus_write(3'd4, 8'h02);
        chk("R9 rts set dtr clear", {dtr_out, rts_out}, 2'b01);
        bus_write(3'd4, 8'h03);
        chk("R9 both set", {dtr_out, rts_out}, 2'b11);
        bus_write(3'd4, 8'h00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bus_addr = 3'd5; bus_wr = 1'b0; bus_rd = 1'b0;
        bus_wdata = 8'h00; rxd_in = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_divisor;
        t_period;
        t_frames;
        t_loop_queue;
        t_receive;
        t_false_start;
        t_modem;
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule